// File: doc/BRIEF.md
# Cascaded 8B/10B Transmit Encoder

This block turns bytes into 8B/10B code groups on the transmit side of a serial link. Each input byte comes with a control flag that selects between the data code space and the control (K) code space. In narrow mode one byte becomes one 10-bit group. In wide mode two bytes become two groups in a single cycle. The two encoder slices are chained, so the lower slice's ending disparity is the upper slice's starting disparity within the same clock.

One register holds the running disparity between accepted words. It starts negative after reset. The disparity register and the outputs change only on cycles where the input is marked valid, and the result appears one cycle later. A force input makes the lower slice start from a disparity picked by the user instead of the tracked one. A control flag on a byte that is not a legal K character raises a per-slice error bit, and that byte is then encoded as data.

Top module: `enc8b10b_cascade`

## Requirements
- R1: In narrow mode (`dbl_i`=0), `data_i[7:0]` and `ctrl_i[0]` encode into `code_o[9:0]` using the standard 8B/10B data and K tables. This includes the alternate D.x.7 form. Code bit a is bit 0, then b, c, d, e, i, f, g, h, and j is bit 9. `code_o[19:10]`, `kerr_o[1]`, the upper byte and `ctrl_i[1]` have no effect and read 0.
- R2: In wide mode (`dbl_i`=1), the lower byte with `ctrl_i[0]` maps to `code_o[9:0]`, and the upper byte with `ctrl_i[1]` maps to `code_o[19:10]`. The upper group starts from the disparity the lower group ends with.
- R3: After reset, `valid_o`, `code_o`, `kerr_o` and `rd_o` are 0, and the first word encodes from negative disparity. For example, K28.5 (0xBC, control) gives `code_o[9:0]`=0x17C.
- R4: While `force_disp_i`=1 on an accepted word, the lower slice starts from `disp_val_i` instead of the stored disparity (1 = positive, 0 = negative).
- R5: Outputs are registered one cycle after a word with `valid_i`=1. `valid_o` follows `valid_i` by one cycle. On cycles with `valid_i`=0 the running disparity is unchanged, whatever the force inputs do.
- R6: The legal K characters are 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD and 0xFE. A control flag on any other byte sets that slice's `kerr_o` bit and emits the data encoding of the byte. A control flag of 0 never sets `kerr_o`.
- R7: Every 10-bit group has 4, 5 or 6 ones. The disparity flips only after a group with 4 or 6 ones. A group with 6 ones can only start from negative disparity, and a group with 4 ones only from positive.
- R8: `rd_o` is the ending disparity of the last accepted word (1 = positive). In narrow mode that is the lower slice's ending disparity, and in wide mode the upper slice's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is accepted this cycle |
| dbl_i | input | 1 | 1 = wide mode (two slices), 0 = narrow mode |
| data_i | input | 16 | Bytes; [7:0] lower, [15:8] upper |
| ctrl_i | input | 2 | Control (K) flag per byte |
| force_disp_i | input | 1 | Override the starting disparity this cycle |
| disp_val_i | input | 1 | Starting disparity when forced (1 = positive) |
| valid_o | output | 1 | Registered output word is valid |
| code_o | output | 20 | Code groups; [9:0] lower, [19:10] upper |
| kerr_o | output | 2 | Illegal control character flag per slice |
| rd_o | output | 1 | Running disparity after the last accepted word |

## Verification
The assertions assume that reset is applied before the first accepted word. They also assume that `valid_i`, `dbl_i`, `force_disp_i` and the data are stable around the clock edge, since the disparity chain is combinational from those inputs to the register. The bench changes all inputs only on the falling edge. It walks every byte, with both flag values and both forced starting disparities, in narrow mode and then in wide mode. It then runs long unforced streams and idle gaps, so that the tracked disparity only ever follows legal code groups.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;
  localparam int SYM_W  = 8;
  localparam int CODE_W = 10;
  localparam int SUB6_W = 6;
  localparam int SUB4_W = 4;

  // legal control characters: K28.y and K23/27/29/30.7
  function automatic logic k_legal(logic [SYM_W-1:0] b);
    logic [4:0] x;
    logic [2:0] y;
    x = b[4:0];
    y = b[7:5];
    return (x == 5'd28) ||
           ((y == 3'd7) && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
  endfunction
endpackage

// File: rtl/enc_6b.sv
module enc_6b
  import enc8b10b_pkg::*;
(
  input  logic [4:0]        x_i,
  input  logic              k28_i,
  input  logic              rd_i,
  output logic [SUB6_W-1:0] sub_o,
  output logic              rd_o
);
  // base holds the negative-column code written a..i from MSB to LSB
  logic [SUB6_W-1:0] base;
  logic [SUB6_W-1:0] pick;
  logic              bal;
  logic              flip;

  always_comb begin
    if (k28_i) begin
      base = 6'b001111;
    end else begin
      case (x_i)
        5'd0:    base = 6'b100111;
        5'd1:    base = 6'b011101;
        5'd2:    base = 6'b101101;
        5'd3:    base = 6'b110001;
        5'd4:    base = 6'b110101;
        5'd5:    base = 6'b101001;
        5'd6:    base = 6'b011001;
        5'd7:    base = 6'b111000;
        5'd8:    base = 6'b111001;
        5'd9:    base = 6'b100101;
        5'd10:   base = 6'b010101;
        5'd11:   base = 6'b110100;
        5'd12:   base = 6'b001101;
        5'd13:   base = 6'b101100;
        5'd14:   base = 6'b011100;
        5'd15:   base = 6'b010111;
        5'd16:   base = 6'b011011;
        5'd17:   base = 6'b100011;
        5'd18:   base = 6'b010011;
        5'd19:   base = 6'b110010;
        5'd20:   base = 6'b001011;
        5'd21:   base = 6'b101010;
        5'd22:   base = 6'b011010;
        5'd23:   base = 6'b111010;
        5'd24:   base = 6'b110011;
        5'd25:   base = 6'b100110;
        5'd26:   base = 6'b010110;
        5'd27:   base = 6'b110110;
        5'd28:   base = 6'b001110;
        5'd29:   base = 6'b101110;
        5'd30:   base = 6'b011110;
        default: base = 6'b101011;
      endcase
    end
  end

  always_comb begin
    bal = ($countones(base) == 3);
    // D.7 is balanced but still has two forms
    if (!k28_i && x_i == 5'd7) flip = rd_i;
    else                       flip = rd_i && !bal;
    pick = flip ? ~base : base;
    for (int i = 0; i < SUB6_W; i++) sub_o[i] = pick[SUB6_W-1-i];
    rd_o = bal ? rd_i : ~rd_i;
  end
endmodule

// File: rtl/enc_4b.sv
module enc_4b
  import enc8b10b_pkg::*;
(
  input  logic [2:0]        y_i,
  input  logic              k_i,
  input  logic              alt_i,
  input  logic              rd_i,
  output logic [SUB4_W-1:0] sub_o,
  output logic              rd_o
);
  // base holds the negative-column code written f..j from MSB to LSB
  logic [SUB4_W-1:0] base;
  logic [SUB4_W-1:0] pick;
  logic              flip;

  always_comb begin
    if (k_i) begin
      case (y_i)
        3'd0:    base = 4'b1011;
        3'd1:    base = 4'b0110;
        3'd2:    base = 4'b1010;
        3'd3:    base = 4'b1100;
        3'd4:    base = 4'b1101;
        3'd5:    base = 4'b0101;
        3'd6:    base = 4'b1001;
        default: base = 4'b0111;
      endcase
    end else if (y_i == 3'd7 && alt_i) begin
      base = 4'b0111;
    end else begin
      case (y_i)
        3'd0:    base = 4'b1011;
        3'd1:    base = 4'b1001;
        3'd2:    base = 4'b0101;
        3'd3:    base = 4'b1100;
        3'd4:    base = 4'b1101;
        3'd5:    base = 4'b1010;
        3'd6:    base = 4'b0110;
        default: base = 4'b1110;
      endcase
    end
  end

  always_comb begin
    // K groups and y=3 invert even when balanced
    flip = rd_i && (k_i || y_i == 3'd3 || $countones(base) != 2);
    pick = flip ? ~base : base;
    for (int i = 0; i < SUB4_W; i++) sub_o[i] = pick[SUB4_W-1-i];
    rd_o = ($countones(base) == 2) ? rd_i : ~rd_i;
  end
endmodule

// File: rtl/enc_slice.sv
module enc_slice
  import enc8b10b_pkg::*;
(
  input  logic [SYM_W-1:0]  byte_i,
  input  logic              ctrl_i,
  input  logic              rd_i,
  output logic [CODE_W-1:0] code_o,
  output logic              rd_o,
  output logic              kerr_o
);
  logic [4:0]        x;
  logic [2:0]        y;
  logic              k_ok;
  logic              k28;
  logic              rd_mid;
  logic              alt;
  logic [SUB6_W-1:0] s6;
  logic [SUB4_W-1:0] s4;

  assign x      = byte_i[4:0];
  assign y      = byte_i[7:5];
  assign k_ok   = ctrl_i && k_legal(byte_i);
  assign k28    = k_ok && (x == 5'd28);
  assign kerr_o = ctrl_i && !k_ok;

  // alternate D.x.7 avoids a run of five equal bits
  assign alt = (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
               ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14));

  enc_6b u_6b (
    .x_i   (x),
    .k28_i (k28),
    .rd_i  (rd_i),
    .sub_o (s6),
    .rd_o  (rd_mid)
  );

  enc_4b u_4b (
    .y_i   (y),
    .k_i   (k_ok),
    .alt_i (alt),
    .rd_i  (rd_mid),
    .sub_o (s4),
    .rd_o  (rd_o)
  );

  assign code_o = {s4, s6};
endmodule

// File: rtl/enc8b10b_cascade.sv
module enc8b10b_cascade
  import enc8b10b_pkg::*;
#(
  parameter int SLICES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic                       dbl_i,
  input  logic [SYM_W*SLICES-1:0]    data_i,
  input  logic [SLICES-1:0]          ctrl_i,
  input  logic                       force_disp_i,
  input  logic                       disp_val_i,
  output logic                       valid_o,
  output logic [CODE_W*SLICES-1:0]   code_o,
  output logic [SLICES-1:0]          kerr_o,
  output logic                       rd_o
);
  localparam int CW = CODE_W * SLICES;

  logic            rd_q;
  logic            valid_q;
  logic [CW-1:0]   code_q;
  logic [SLICES-1:0] kerr_q;

  logic [SLICES:0]   rd_chain;
  logic [CW-1:0]     code_w;
  logic [CW-1:0]     code_m;
  logic [SLICES-1:0] kerr_w;
  logic [SLICES-1:0] kerr_m;
  logic [SLICES-1:0] act;
  logic              rd_end;

  assign rd_chain[0] = force_disp_i ? disp_val_i : rd_q;

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    enc_slice u_slice (
      .byte_i (data_i[g*SYM_W +: SYM_W]),
      .ctrl_i (ctrl_i[g]),
      .rd_i   (rd_chain[g]),
      .code_o (code_w[g*CODE_W +: CODE_W]),
      .rd_o   (rd_chain[g+1]),
      .kerr_o (kerr_w[g])
    );
    assign act[g] = (g == 0) || dbl_i;
    assign code_m[g*CODE_W +: CODE_W] = act[g] ? code_w[g*CODE_W +: CODE_W] : '0;
    assign kerr_m[g] = act[g] && kerr_w[g];
  end

  assign rd_end = dbl_i ? rd_chain[SLICES] : rd_chain[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      valid_q <= 1'b0;
      code_q  <= '0;
      kerr_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        code_q <= code_m;
        kerr_q <= kerr_m;
        rd_q   <= rd_end;
      end
    end
  end

  assign valid_o = valid_q;
  assign code_o  = code_q;
  assign kerr_o  = kerr_q;
  assign rd_o    = rd_q;

  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));

  p_rd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(rd_o));

  p_flip_unbal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ((rd_chain[1] != rd_chain[0]) == ($countones(code_w[CODE_W-1:0]) != 5)));

  p_heavy_from_neg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ($countones(code_w[CODE_W-1:0]) == 6) |-> !rd_chain[0]);

  p_ones_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(code_o[CODE_W-1:0]) >= 4 && $countones(code_o[CODE_W-1:0]) <= 6));

  p_upper_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !dbl_i |=> ((code_o >> CODE_W) == '0) && ((kerr_o >> 1) == '0));

  p_no_kerr_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ctrl_i[0] |=> !kerr_o[0]);
endmodule

// File: tb/enc8b10b_cascade_tb_top.sv
module enc8b10b_cascade_tb_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        dbl_i = 1'b0;
  logic [15:0] data_i = '0;
  logic [1:0]  ctrl_i = '0;
  logic        force_disp_i = 1'b0;
  logic        disp_val_i = 1'b0;
  logic        valid_o;
  logic [19:0] code_o;
  logic [1:0]  kerr_o;
  logic        rd_o;

  int checks = 0;
  int failures = 0;
  logic model_rd = 1'b0;
  bit done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  enc8b10b_cascade dut_i (
    .clk_i, .rst_ni, .valid_i, .dbl_i, .data_i, .ctrl_i,
    .force_disp_i, .disp_val_i, .valid_o, .code_o, .kerr_o, .rd_o
  );

  // {negative column, positive column}, written a..i left to right
  function automatic logic [11:0] col6(int x);
    case (x)
      0:  return {6'b100111, 6'b011000};
      1:  return {6'b011101, 6'b100010};
      2:  return {6'b101101, 6'b010010};
      3:  return {6'b110001, 6'b110001};
      4:  return {6'b110101, 6'b001010};
      5:  return {6'b101001, 6'b101001};
      6:  return {6'b011001, 6'b011001};
      7:  return {6'b111000, 6'b000111};
      8:  return {6'b111001, 6'b000110};
      9:  return {6'b100101, 6'b100101};
      10: return {6'b010101, 6'b010101};
      11: return {6'b110100, 6'b110100};
      12: return {6'b001101, 6'b001101};
      13: return {6'b101100, 6'b101100};
      14: return {6'b011100, 6'b011100};
      15: return {6'b010111, 6'b101000};
      16: return {6'b011011, 6'b100100};
      17: return {6'b100011, 6'b100011};
      18: return {6'b010011, 6'b010011};
      19: return {6'b110010, 6'b110010};
      20: return {6'b001011, 6'b001011};
      21: return {6'b101010, 6'b101010};
      22: return {6'b011010, 6'b011010};
      23: return {6'b111010, 6'b000101};
      24: return {6'b110011, 6'b001100};
      25: return {6'b100110, 6'b100110};
      26: return {6'b010110, 6'b010110};
      27: return {6'b110110, 6'b001001};
      28: return {6'b001110, 6'b001110};
      29: return {6'b101110, 6'b010001};
      30: return {6'b011110, 6'b100001};
      default: return {6'b101011, 6'b010100};
    endcase
  endfunction

  function automatic logic [7:0] col4d(int y);
    case (y)
      0: return {4'b1011, 4'b0100};
      1: return {4'b1001, 4'b1001};
      2: return {4'b0101, 4'b0101};
      3: return {4'b1100, 4'b0011};
      4: return {4'b1101, 4'b0010};
      5: return {4'b1010, 4'b1010};
      6: return {4'b0110, 4'b0110};
      default: return {4'b1110, 4'b0001};
    endcase
  endfunction

  function automatic logic [7:0] col4k(int y);
    case (y)
      0: return {4'b1011, 4'b0100};
      1: return {4'b0110, 4'b1001};
      2: return {4'b1010, 4'b0101};
      3: return {4'b1100, 4'b0011};
      4: return {4'b1101, 4'b0010};
      5: return {4'b0101, 4'b1010};
      6: return {4'b1001, 4'b0110};
      default: return {4'b0111, 4'b1000};
    endcase
  endfunction

  task automatic ref_enc(input logic [7:0] b, input logic k, input logic rd,
                         output logic [9:0] code, output logic rd_end, output logic ke);
    int x, y;
    logic kok, r1;
    logic [11:0] t6;
    logic [7:0] t4;
    logic [5:0] s;
    logic [3:0] f;
    x = int'(b[4:0]);
    y = int'(b[7:5]);
    kok = k && (x == 28 || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30)));
    ke = k && !kok;
    t6 = (kok && x == 28) ? {6'b001111, 6'b110000} : col6(x);
    s = rd ? t6[5:0] : t6[11:6];
    if ($countones(s) == 3) r1 = rd;
    else r1 = ($countones(s) == 4);
    if (kok) t4 = col4k(y);
    else if (y == 7 && ((!r1 && (x == 17 || x == 18 || x == 20)) ||
                        (r1 && (x == 11 || x == 13 || x == 14)))) t4 = {4'b0111, 4'b1000};
    else t4 = col4d(y);
    f = r1 ? t4[3:0] : t4[7:4];
    for (int i = 0; i < 6; i++) code[i] = s[5-i];
    for (int i = 0; i < 4; i++) code[6+i] = f[3-i];
    if ($countones(code) == 5) rd_end = rd;
    else rd_end = ($countones(code) == 6);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input logic v, input logic dbl, input logic [15:0] d,
                      input logic [1:0] k, input logic f, input logic fv, input string req);
    logic [9:0] c0, c1;
    logic r0, r1, e0, e1, start, endrd;
    logic [19:0] exp_code;
    logic [1:0] exp_kerr;
    start = f ? fv : model_rd;
    ref_enc(d[7:0], k[0], start, c0, r0, e0);
    ref_enc(d[15:8], k[1], r0, c1, r1, e1);
    exp_code = dbl ? {c1, c0} : {10'b0, c0};
    exp_kerr = dbl ? {e1, e0} : {1'b0, e0};
    endrd = dbl ? r1 : r0;
    if (v) model_rd = endrd;
    valid_i = v; dbl_i = dbl; data_i = d; ctrl_i = k;
    force_disp_i = f; disp_val_i = fv;
    @(negedge clk_i);
    if (v) begin
      check(valid_o === 1'b1 && code_o === exp_code && kerr_o === exp_kerr && rd_o === model_rd,
            req, "word", {valid_o, kerr_o, rd_o, code_o}, {1'b1, exp_kerr, model_rd, exp_code});
    end else begin
      check(valid_o === 1'b0 && rd_o === model_rd, req, "idle",
            {valid_o, rd_o}, {1'b0, model_rd});
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R3: reset state
    check(valid_o === 1'b0 && code_o === '0 && kerr_o === '0 && rd_o === 1'b0, "R3", "reset",
          {valid_o, kerr_o, rd_o, code_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    model_rd = 1'b0;

    // R3: first word from negative disparity, K28.5 golden value
    step(1, 0, 16'h00BC, 2'b01, 0, 0, "R3");
    check(code_o[9:0] === 10'h17C, "R3", "K28.5 golden", code_o[9:0], 10'h17C);
    // R1: D21.5 from positive disparity, golden value
    step(1, 0, 16'h00B5, 2'b00, 0, 0, "R1");
    check(code_o[9:0] === 10'h155, "R1", "D21.5 golden", code_o[9:0], 10'h155);

    // R1/R6/R4: full narrow-mode sweep, upper byte and flag are junk
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 2; k++)
        for (int b = 0; b < 256; b++)
          step(1, 0, {8'(b) ^ 8'h5A, 8'(b)}, {1'b1, 1'(k)}, 1, 1'(r), k ? "R6" : "R1");

    // R2/R4: wide-mode sweep, force every fifth word
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 256; b++) begin
        logic [7:0] up;
        up = 8'(b * 7 + 3);
        if (k[1] && (b % 3 == 0)) up = 8'hBC;
        if (b % 5 == 0) step(1, 1, {up, 8'(b)}, 2'(k), 1, 1'(b[3]), "R4");
        else            step(1, 1, {up, 8'(b)}, 2'(k), 0, 0, "R2");
      end

    // R7/R8: unforced streams tracking disparity, mixed widths
    for (int i = 0; i < 300; i++) begin
      logic [7:0] lo;
      logic kk;
      lo = 8'(i * 29 + 1);
      kk = (i % 17 == 0);
      if (kk) lo = 8'h7C;
      step(1, 1'(i % 3 == 1), {8'(i * 13), lo}, {1'b0, kk}, 0, 0, "R8");
      check($countones(code_o[9:0]) >= 4 && $countones(code_o[9:0]) <= 6, "R7", "ones",
            $countones(code_o[9:0]), 5);
    end

    // R5: idle cycles with force asserted leave the disparity alone
    for (int i = 0; i < 16; i++) begin
      step(0, 1'(i[0]), 16'hFFFF, 2'b11, 1, ~model_rd, "R5");
      step(0, 0, 16'h0000, 2'b00, 1, model_rd, "R5");
      step(1, 1'(i[1]), {8'(i * 11), 8'(i * 5 + 2)}, 2'b00, 0, 0, "R5");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule